// File: doc/BRIEF.md
# Sequential Byte-Program Flash Controller

This block is the device side of a serial flash that accepts a stream of single-byte writes without a fresh address for each one. A host talks to it over SPI (mode 0, MSB first) with chip select framing each command. After the write-enable latch has been set, the host opens an auto-increment program sequence by sending one of two program opcodes, a 24-bit start address and a data byte. Each later frame carries only the opcode and a byte, and that byte lands at the next address. Releasing chip select starts a self-timed program of fixed length. During that time a status byte that the host can poll shows the device as busy.

The sequence ends when the host sends write disable, when a frame is cut short, or on its own. It ends by itself once the top byte of the array has been written, or once the next address would fall into a write-protected sector. Each sector has one protect bit on an input vector. Programming can only clear bits: the stored byte becomes the old byte ANDed with the data, and an error flag is raised when the result differs from the data. The byte array is a synchronous memory. It has a second port through which the surrounding test or boot logic can preload it (to the erased value FFh, for instance) and read it back. SPI pins are sampled in the `clk_i` domain, and the SPI clock must be slower than a quarter of `clk_i`.

Top module: `seqprog_flash`

## Requirements
- R1: Opcode 05h returns the status byte on `miso_o`, MSB first, in every byte that follows the opcode. Its bits are: bit 0 busy, bit 1 write-enable latch, bit 5 program error, all other bits 0. `miso_o` is 0 while `cs_ni` is high.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it. Each takes effect when `cs_ni` rises on a byte boundary. Opcode 04h also ends an active program sequence, so a later data-only frame is treated as a new first frame.
- R3: A program frame (opcode ADh or AFh) sent while the write-enable latch is 0 is ignored. It programs nothing and changes no status bit.
- R4: First frame: opcode, three address bytes (MSB first, only the low `ADDR_W` bits are used), then a data byte. When `cs_ni` rises, the addressed byte becomes old AND data, and busy reads 1 for `PROG_CYCLES` clock cycles.
- R5: While a sequence is active, a frame of opcode plus one data byte programs the address after the previous one. The write-enable latch stays 1 and does not need to be set again.
- R6: When more than one data byte is shifted within a frame, only the last complete byte is programmed.
- R7: If `cs_ni` rises off a byte boundary, or before the data byte is complete, nothing is programmed. The write-enable latch is cleared and any sequence ends.
- R8: A first frame whose address lies in a protected sector (sector = address bits `ADDR_W-1:SECT_W`, protected when that bit of `protect_i` is 1) programs nothing and clears the write-enable latch.
- R9: After the byte at the highest array address is programmed, the sequence ends and the write-enable latch is cleared when busy drops.
- R10: After the last byte before a protected sector is programmed, the sequence ends and the write-enable latch is cleared when busy drops.
- R11: The program-error bit is set when the stored result differs from the data byte. It is cleared when the next program starts.
- R12: While busy, every frame except the status read is ignored, including write disable.
- R13: The preload port writes a byte into the array, and the read-back port returns the stored byte one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI clock, mode 0 |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host (status) |
| protect_i | input | 2^(ADDR_W-SECT_W) | One write-protect bit per sector |
| pl_we_i | input | 1 | Preload write strobe |
| pl_addr_i | input | ADDR_W | Preload write address |
| pl_data_i | input | 8 | Preload write data |
| pl_raddr_i | input | ADDR_W | Read-back address |
| pl_rdata_o | output | 8 | Read-back data, one cycle latency |

## Verification
The assertions check the following on every cycle. `miso_o` stays quiet outside a frame. An active sequence always implies a set write-enable latch, and every exit from a sequence leaves that latch cleared. A program never starts without the latch. Busy only rises after a chip-select release and lasts exactly `PROG_CYCLES` cycles, and array writes happen only while busy. The bench scenarios cover the things that depend on what was shifted in: which address and which byte land in the array, how aborts at odd bit counts behave, how a protected start and the two automatic exits (array top and protected boundary) work, the sticky-until-next-program error flag, and the frames that are ignored while busy. A final sweep compares the whole array against the bench model.

// File: rtl/seqprog_pkg.sv
package seqprog_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_SEQ_A = 8'hAD;
  localparam logic [7:0] OP_SEQ_B = 8'hAF;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_READ,
    PH_WRITE
  } prog_phase_e;

  function automatic logic [7:0] pack_status(logic busy, logic wel, logic err);
    return {2'b00, err, 3'b000, wel, busy};
  endfunction
endpackage

// File: rtl/spi_shifter.sv
module spi_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic [2:0] byte_cnt_o,
  output logic       aligned_o,
  output logic       frame_end_o,
  input  logic       tx_req_i,
  input  logic [7:0] tx_byte_i
);
  logic       sck_q, cs_q;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [7:0] tx_q, tx_hold;
  logic       tx_pend;
  logic       sck_rise, sck_fall, frame_start;

  assign sck_rise    = !cs_ni && sck_i && !sck_q;
  assign sck_fall    = !cs_ni && !sck_i && sck_q;
  assign frame_start = !cs_ni && cs_q;
  assign frame_end_o = cs_ni && !cs_q;
  assign aligned_o   = (bit_cnt == 3'd0);
  assign miso_o      = !cs_ni && tx_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      bit_cnt    <= '0;
      shreg      <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      byte_cnt_o <= '0;
      tx_q       <= '0;
      tx_hold    <= '0;
      tx_pend    <= 1'b0;
    end else begin
      sck_q      <= sck_i;
      cs_q       <= cs_ni;
      rx_valid_o <= 1'b0;
      if (frame_start) begin
        bit_cnt    <= '0;
        byte_cnt_o <= '0;
        tx_q       <= '0;
        tx_pend    <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg   <= {shreg[5:0], mosi_i};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_byte_o  <= {shreg, mosi_i};
            rx_valid_o <= 1'b1;
            if (byte_cnt_o != 3'd7) byte_cnt_o <= byte_cnt_o + 3'd1;
          end
        end
        if (sck_fall) begin
          if (tx_pend) begin
            tx_q    <= tx_hold;
            tx_pend <= 1'b0;
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end
        if (rx_valid_o && tx_req_i) begin
          tx_pend <= 1'b1;
          tx_hold <= tx_byte_i;
        end
      end
    end
  end
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CYCLES = 200,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/byte_array.sv
module byte_array #(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_we_i,
  input  logic [7:0]        a_wdata_i,
  output logic [7:0]        a_rdata_o,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_waddr_i,
  input  logic [7:0]        b_wdata_i,
  input  logic [ADDR_W-1:0] b_raddr_i,
  output logic [7:0]        b_rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (b_we_i) mem[b_waddr_i] <= b_wdata_i;
    if (a_we_i) mem[a_addr_i]  <= a_wdata_i;
    a_rdata_o <= mem[a_addr_i];
    b_rdata_o <= mem[b_raddr_i];
  end
endmodule

// File: rtl/seqprog_ctrl.sv
module seqprog_ctrl
  import seqprog_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SECT_W = 8,
  localparam int NUM_SECT = 1 << (ADDR_W - SECT_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic [7:0]          rx_byte_i,
  input  logic [2:0]          byte_cnt_i,
  input  logic                aligned_i,
  input  logic                frame_end_i,
  output logic                tx_req_o,
  output logic [7:0]          tx_byte_o,
  input  logic [NUM_SECT-1:0] protect_i,
  input  logic                busy_i,
  input  logic                done_i,
  output logic                start_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_we_o,
  output logic [7:0]          mem_wdata_o,
  input  logic [7:0]          mem_rdata_i,
  output logic                wel_o,
  output logic                mode_o
);
  logic [7:0]        op_q, data_q, prog_data_q;
  logic [ADDR_W-1:0] addr_q, cur_q, prog_addr_q, go_addr, nxt_addr;
  logic              wel_q, mode_q, err_q;
  prog_phase_e       phase_q;
  logic              is_seq, cmd_ok, go, set_wel, clr_wel, set_mode, clr_mode, auto_exit;

  assign is_seq   = (op_q == OP_SEQ_A) || (op_q == OP_SEQ_B);
  assign cmd_ok   = frame_end_i && (byte_cnt_i != 3'd0) && !busy_i;
  assign nxt_addr = prog_addr_q + ADDR_W'(1);
  assign auto_exit = done_i && mode_q &&
                     ((prog_addr_q == {ADDR_W{1'b1}}) || protect_i[nxt_addr[ADDR_W-1:SECT_W]]);

  always_comb begin
    go       = 1'b0;
    go_addr  = cur_q;
    set_wel  = 1'b0;
    clr_wel  = 1'b0;
    set_mode = 1'b0;
    clr_mode = 1'b0;
    if (cmd_ok) begin
      if (op_q == OP_WREN) begin
        set_wel = aligned_i;
      end else if (op_q == OP_WRDI) begin
        clr_wel  = aligned_i;
        clr_mode = aligned_i;
      end else if (is_seq && wel_q) begin
        if (!mode_q) begin
          if (!aligned_i || byte_cnt_i < 3'd5) begin
            clr_wel = 1'b1;
          end else if (protect_i[addr_q[ADDR_W-1:SECT_W]]) begin
            clr_wel = 1'b1;
          end else begin
            go       = 1'b1;
            go_addr  = addr_q;
            set_mode = 1'b1;
          end
        end else if (!aligned_i || byte_cnt_i < 3'd2) begin
          clr_wel  = 1'b1;
          clr_mode = 1'b1;
        end else begin
          go = 1'b1;
        end
      end
    end
  end

  assign start_o     = go;
  assign mem_addr_o  = prog_addr_q;
  assign mem_we_o    = (phase_q == PH_WRITE);
  assign mem_wdata_o = mem_rdata_i & prog_data_q;
  assign tx_byte_o   = pack_status(busy_i, wel_q, err_q);
  assign tx_req_o    = rx_valid_i &&
                       ((byte_cnt_i == 3'd1) ? (rx_byte_i == OP_RDSR) : (op_q == OP_RDSR));
  assign wel_o       = wel_q;
  assign mode_o      = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q        <= '0;
      data_q      <= '0;
      addr_q      <= '0;
      cur_q       <= '0;
      prog_addr_q <= '0;
      prog_data_q <= '0;
      wel_q       <= 1'b0;
      mode_q      <= 1'b0;
      err_q       <= 1'b0;
      phase_q     <= PH_IDLE;
    end else begin
      if (rx_valid_i) begin
        if (byte_cnt_i == 3'd1) begin
          op_q <= rx_byte_i;
        end else begin
          data_q <= rx_byte_i;  // last complete byte wins
          if (!mode_q && byte_cnt_i <= 3'd4) addr_q <= ADDR_W'({addr_q, rx_byte_i});
        end
      end

      if (clr_wel || auto_exit) wel_q <= 1'b0;
      else if (set_wel)         wel_q <= 1'b1;

      if (clr_mode || auto_exit) mode_q <= 1'b0;
      else if (set_mode)         mode_q <= 1'b1;

      if (done_i && mode_q && !auto_exit) cur_q <= nxt_addr;

      case (phase_q)
        PH_READ:  phase_q <= PH_WRITE;
        PH_WRITE: begin
          err_q   <= (mem_wdata_o != prog_data_q);
          phase_q <= PH_IDLE;
        end
        default: begin
          if (go) begin
            prog_addr_q <= go_addr;
            prog_data_q <= data_q;
            err_q       <= 1'b0;
            phase_q     <= PH_READ;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/seqprog_flash.sv
module seqprog_flash #(
  parameter int ADDR_W      = 11,
  parameter int SECT_W      = 8,
  parameter int PROG_CYCLES = 200,
  localparam int NUM_SECT   = 1 << (ADDR_W - SECT_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sck_i,
  input  logic                mosi_i,
  output logic                miso_o,
  input  logic [NUM_SECT-1:0] protect_i,
  input  logic                pl_we_i,
  input  logic [ADDR_W-1:0]   pl_addr_i,
  input  logic [7:0]          pl_data_i,
  input  logic [ADDR_W-1:0]   pl_raddr_i,
  output logic [7:0]          pl_rdata_o
);
  logic              rx_valid, aligned, frame_end, tx_req;
  logic [7:0]        rx_byte, tx_byte;
  logic [2:0]        byte_cnt;
  logic              timer_start, busy, done, wel, mode, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;

  spi_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sck_i       (sck_i),
    .mosi_i      (mosi_i),
    .miso_o      (miso_o),
    .rx_valid_o  (rx_valid),
    .rx_byte_o   (rx_byte),
    .byte_cnt_o  (byte_cnt),
    .aligned_o   (aligned),
    .frame_end_o (frame_end),
    .tx_req_i    (tx_req),
    .tx_byte_i   (tx_byte)
  );

  seqprog_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid),
    .rx_byte_i   (rx_byte),
    .byte_cnt_i  (byte_cnt),
    .aligned_i   (aligned),
    .frame_end_i (frame_end),
    .tx_req_o    (tx_req),
    .tx_byte_o   (tx_byte),
    .protect_i   (protect_i),
    .busy_i      (busy),
    .done_i      (done),
    .start_o     (timer_start),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .wel_o       (wel),
    .mode_o      (mode)
  );

  prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (timer_start),
    .busy_o  (busy),
    .done_o  (done)
  );

  byte_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i     (clk_i),
    .a_addr_i  (mem_addr),
    .a_we_i    (mem_we),
    .a_wdata_i (mem_wdata),
    .a_rdata_o (mem_rdata),
    .b_we_i    (pl_we_i),
    .b_waddr_i (pl_addr_i),
    .b_wdata_i (pl_data_i),
    .b_raddr_i (pl_raddr_i),
    .b_rdata_o (pl_rdata_o)
  );
endmodule

// File: rtl/seqprog_flash_chk.sv
module seqprog_flash_chk #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic miso_o,
  input logic frame_end,
  input logic timer_start,
  input logic busy,
  input logic wel,
  input logic mode,
  input logic mem_we
);
  int busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  assert_miso_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !miso_o);

  assert_mode_has_wel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode |-> wel);

  assert_start_needs_wel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_start |-> wel);

  assert_busy_after_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(frame_end));

  assert_busy_length_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (busy_len == PROG_CYCLES));

  assert_write_while_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy);

  assert_exit_clears_wel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode) |-> !wel);

  assert_no_start_when_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !timer_start);
endmodule

bind seqprog_flash seqprog_flash_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .miso_o      (miso_o),
  .frame_end   (frame_end),
  .timer_start (timer_start),
  .busy        (busy),
  .wel         (wel),
  .mode        (mode),
  .mem_we      (mem_we)
);

// File: tb/seqprog_flash_bench.sv
`timescale 1ns/1ps
module seqprog_flash_bench;
  localparam int AW = 11;
  localparam int SW = 8;
  localparam int PC = 200;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, mosi, miso;
  logic [7:0] protect;
  logic pl_we;
  logic [AW-1:0] pl_addr, pl_raddr;
  logic [7:0] pl_data, pl_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  logic [7:0] mdl [DEPTH];
  logic [7:0] st, rd;

  always #2 clk = ~clk;

  seqprog_flash #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYCLES(PC)) u_seqprog_flash (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi), .miso_o(miso),
    .protect_i(protect), .pl_we_i(pl_we), .pl_addr_i(pl_addr), .pl_data_i(pl_data),
    .pl_raddr_i(pl_raddr), .pl_rdata_o(pl_rdata)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int nbytes, input int xbits);
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nbytes * 8 + xbits; i++) begin
      mosi = txb[i/8][7 - (i%8)];
      tick(4);
      rxb[i/8][7 - (i%8)] = miso;
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
    end
    tick(4);
    cs_n = 1'b1;
    mosi = 1'b0;
    tick(6);
  endtask

  task automatic status(output logic [7:0] s);
    txb[0] = 8'h05;
    xfer(2, 0);
    s = rxb[1];
  endtask

  task automatic cmd(input logic [7:0] op);
    txb[0] = op;
    xfer(1, 0);
  endtask

  task automatic seq_first(input logic [7:0] op, input int a, input logic [7:0] d);
    txb[0] = op;
    txb[1] = 8'h00;
    txb[2] = 8'((a >> 8) & 'hFF);
    txb[3] = 8'(a & 'hFF);
    txb[4] = d;
    xfer(5, 0);
  endtask

  task automatic seq_next(input logic [7:0] op, input logic [7:0] d);
    txb[0] = op;
    txb[1] = d;
    xfer(2, 0);
  endtask

  task automatic wait_prog();
    tick(PC + 20);
  endtask

  task automatic mem_rd(input int a, output logic [7:0] d);
    pl_raddr = AW'(a);
    tick(2);
    d = pl_rdata;
  endtask

  task automatic check_mem(input string tag, input int a);
    logic [7:0] d;
    mem_rd(a, d);
    chk(tag, d, mdl[a]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; protect = '0;
    pl_we = 1'b0; pl_addr = '0; pl_data = '0; pl_raddr = '0;
    tick(5);
    rst_n = 1'b1;
    tick(3);

    // erase preload
    for (int a = 0; a < DEPTH; a++) begin
      pl_we = 1'b1; pl_addr = AW'(a); pl_data = 8'hFF; mdl[a] = 8'hFF;
      tick(1);
    end
    pl_we = 1'b1; pl_addr = AW'('h112); pl_data = 8'h0F; mdl['h112] = 8'h0F;
    tick(1);
    pl_we = 1'b0;
    check_mem("R13 preload readback", 'h112);
    check_mem("R13 erased readback", 'h111);

    // reset state
    status(st);
    chk("R1 reset status", st, 8'h00);

    // program frame without write enable
    seq_first(8'hAD, 'h010, 8'h00);
    wait_prog();
    status(st);
    chk("R3 status after ignored program", st, 8'h00);
    check_mem("R3 array untouched", 'h010);

    // write enable and repeated status bytes
    cmd(8'h06);
    txb[0] = 8'h05;
    xfer(4, 0);
    chk("R2 wel set", rxb[1], 8'h02);
    chk("R1 status repeat 2", rxb[2], 8'h02);
    chk("R1 status repeat 3", rxb[3], 8'h02);

    // first frame, busy visible
    seq_first(8'hAF, 'h100, 8'hA5);
    mdl['h100] = mdl['h100] & 8'hA5;
    status(st);
    chk("R4 busy during program", st, 8'h03);
    wait_prog();
    status(st);
    chk("R4 idle after program", st, 8'h02);
    check_mem("R4 first byte", 'h100);

    // sequential sweep
    for (int i = 1; i < 16; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 5) & 'hFF);
      seq_next((i % 2) ? 8'hAD : 8'hAF, d);
      mdl['h100 + i] = mdl['h100 + i] & d;
      wait_prog();
      status(st);
      chk("R5 wel kept", st, 8'h02);
      check_mem("R5 sequential byte", 'h100 + i);
    end

    // several data bytes in one frame
    txb[0] = 8'hAD; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33;
    xfer(4, 0);
    mdl['h110] = mdl['h110] & 8'h33;
    // write disable while busy is ignored
    cmd(8'h04);
    wait_prog();
    check_mem("R6 last byte kept", 'h110);
    status(st);
    chk("R12 wrdi ignored while busy", st, 8'h02);
    seq_next(8'hAD, 8'h6C);
    mdl['h111] = mdl['h111] & 8'h6C;
    wait_prog();
    check_mem("R12 sequence continued", 'h111);

    // program error on non-erased byte
    seq_next(8'hAF, 8'hF0);
    mdl['h112] = mdl['h112] & 8'hF0;
    wait_prog();
    status(st);
    chk("R11 error flag set", st, 8'h22);
    check_mem("R11 and result", 'h112);
    seq_next(8'hAD, 8'h5A);
    mdl['h113] = mdl['h113] & 8'h5A;
    wait_prog();
    status(st);
    chk("R11 error cleared", st, 8'h02);
    check_mem("R11 clean byte", 'h113);

    // abort mid-byte
    txb[0] = 8'hAD; txb[1] = 8'h77;
    xfer(1, 4);
    wait_prog();
    status(st);
    chk("R7 abort clears wel", st, 8'h00);
    check_mem("R7 no program on abort", 'h114);
    cmd(8'h06);
    seq_next(8'hAD, 8'h77);
    wait_prog();
    status(st);
    chk("R7 mode ended after abort", st, 8'h00);
    check_mem("R7 still unprogrammed", 'h114);
    cmd(8'h06);
    txb[0] = 8'hAF; txb[1] = 8'h00; txb[2] = 8'h01; txb[3] = 8'h20;
    xfer(4, 0);
    wait_prog();
    status(st);
    chk("R7 missing data byte aborts", st, 8'h00);
    check_mem("R7 address unprogrammed", 'h120);

    // write disable ends the sequence
    cmd(8'h06);
    seq_first(8'hAD, 'h200, 8'h11);
    mdl['h200] = mdl['h200] & 8'h11;
    wait_prog();
    cmd(8'h04);
    status(st);
    chk("R2 wrdi clears wel", st, 8'h00);
    cmd(8'h06);
    seq_next(8'hAD, 8'h22);
    wait_prog();
    status(st);
    chk("R2 sequence ended by wrdi", st, 8'h00);
    check_mem("R2 first byte", 'h200);
    check_mem("R2 next not programmed", 'h201);

    // protected start
    protect = 8'b0000_1000;
    cmd(8'h06);
    seq_first(8'hAF, 'h310, 8'h00);
    wait_prog();
    status(st);
    chk("R8 protected start clears wel", st, 8'h00);
    check_mem("R8 protected untouched", 'h310);

    // exit before protected sector
    cmd(8'h06);
    seq_first(8'hAD, 'h2FE, 8'hC3);
    mdl['h2FE] = mdl['h2FE] & 8'hC3;
    wait_prog();
    status(st);
    chk("R10 mode running", st, 8'h02);
    seq_next(8'hAF, 8'h3C);
    mdl['h2FF] = mdl['h2FF] & 8'h3C;
    wait_prog();
    status(st);
    chk("R10 exit at protected boundary", st, 8'h00);
    check_mem("R10 byte before boundary", 'h2FF);

    // exit at array top
    protect = '0;
    cmd(8'h06);
    seq_first(8'hAF, 'h7FE, 8'h81);
    mdl['h7FE] = mdl['h7FE] & 8'h81;
    wait_prog();
    status(st);
    chk("R9 mode running", st, 8'h02);
    seq_next(8'hAD, 8'h18);
    mdl['h7FF] = mdl['h7FF] & 8'h18;
    wait_prog();
    status(st);
    chk("R9 exit at array top", st, 8'h00);
    check_mem("R9 top byte", 'h7FF);
    check_mem("R9 no wrap to zero", 'h000);

    // full array comparison against model
    for (int a = 0; a < DEPTH; a++) check_mem("R4 array sweep", a);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule